// File: doc/BRIEF.md
# Transactional Memory Command Issue Unit

This unit sits beside a load/store pipeline and turns transactional-memory commands (begin, commit, abort) into requests for the data-cache port. A command arrives with its kind, a transaction id and a nested flag. A nested begin or commit never leaves the core: the unit answers it itself with all-zero data.

Any other command is formatted as an 8-byte read of physical address zero. It skips address translation and goes out on a valid/ready request port the cycle after acceptance. For these commands the return buffer is preset to 1. The cache overwrites it with 0 on success, so a completion value of 1 signals failure. The completion, carrying the id and 64-bit data, goes to writeback.

An abort is sent as a strictly ordered, physical read carrying an abort marker, the cause code and the transaction id. In the cycle before it goes out, the unit pulses clear strobes to the dispatch-side and commit-side start/stop counters. While any command is in flight, the unit holds both the load barrier and the store barrier. Only one command may be in flight at a time.

Top module: `txcmd_issue`

## Requirements
- R1: A begin or commit that is not nested is offered on the request port in the cycle after acceptance. The request has address 0, size 8 and flags 4'b0011. Flag bit0 means transactional command, bit1 physical, bit2 strictly ordered and bit3 abort notice. The request also carries the command's kind and id, and cause 0. Kind encoding: 0 begin, 1 commit, 2 abort; any kind with bit1 set is treated as abort.
- R2: A nested begin or commit produces cplValid with cplData 0 and the command's id in the cycle after acceptance, and it never raises reqValid.
- R3: For a command sent to the cache, cplValid rises the cycle after the matching response, and cplData equals the response data. An abort refused by the cache completes with cplData 1, the preset value.
- R4: holdLoads and holdStores are both high from the cycle after acceptance through the completion cycle, and both are low in the cycle after completion.
- R5: cmdReady is high only when no command is in flight, so a second command is stalled until the first completes.
- R6: An abort request has address 0, size 8, flags 4'b1110, kind 2, and carries the command's cause and id.
- R7: clrDispatchCnt and clrCommitCnt pulse together for exactly one cycle. That cycle is the one just before the abort request is first offered.
- R8: An abort request is offered for a single cycle. If reqReady is low in that cycle, errRefused becomes set and stays set until reset. errRefused stays low when every abort is taken.
- R9: A response whose rspUid differs from the in-flight id is ignored, and no completion follows it. errUidMismatch becomes set and stays set until reset.
- R10: A begin or commit request stays valid with a stable id and kind until reqReady is seen high.
- R11: After reset: cmdReady is 1, and reqValid, cplValid, both holds, both clears and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit idle, command taken when valid |
| cmdKind | input | 2 | 0 begin, 1 commit, 2 abort |
| cmdUid | input | UID_W | Transaction id |
| cmdNested | input | 1 | Nested begin/commit, answered locally |
| abortCause | input | CAUSE_W | Cause code for an abort |
| reqValid | output | 1 | Request to data cache valid |
| reqReady | input | 1 | Data cache accepts request |
| reqAddr | output | ADDR_W | Request address, always 0 |
| reqSize | output | 4 | Request size in bytes, always 8 |
| reqKind | output | 2 | Kind of the in-flight command |
| reqFlags | output | 4 | bit0 command, bit1 physical, bit2 strict, bit3 abort |
| reqUid | output | UID_W | Transaction id of the request |
| reqCause | output | CAUSE_W | Abort cause, 0 for begin/commit |
| rspValid | input | 1 | Response from data cache |
| rspUid | input | UID_W | Id carried by the response |
| rspData | input | DATA_W | Response data, 0 on success |
| cplValid | output | 1 | Completion to writeback |
| cplUid | output | UID_W | Id of the completed command |
| cplData | output | DATA_W | Completion data |
| holdLoads | output | 1 | Younger loads blocked |
| holdStores | output | 1 | Younger stores blocked |
| clrDispatchCnt | output | 1 | Clear dispatch-side start/stop counters |
| clrCommitCnt | output | 1 | Clear commit-side start/stop counters |
| errRefused | output | 1 | Sticky: abort notice refused |
| errUidMismatch | output | 1 | Sticky: response id mismatch |

## Verification
The assertions check the following on every cycle:
- no request is offered while a command can still be accepted;
- acceptance raises both barriers, and completion drops them;
- a nested begin or commit gets its zero-data reply on the next cycle;
- a pending begin or commit request holds steady;
- the counter clears come just before the first abort request;
- each error flag rises only after the event that justifies it.

Only the bench scenarios can show the following:
- the full request format;
- the response data passing through;
- the preset value of 1 on a refused abort;
- the completion cycle for each handshake delay;
- that a mismatched response really leaves the unit waiting.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;

  typedef enum logic [1:0] {
    TX_BEGIN  = 2'd0,
    TX_COMMIT = 2'd1,
    TX_ABORT  = 2'd2
  } txKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCAL,
    ST_CLEAR,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch command fields
    logic presetBuf; // return buffer <= 1
    logic zeroBuf;   // return buffer <= 0 (local reply)
    logic loadRsp;   // return buffer <= response data
  } txStrobe_t;

  localparam int FLAG_W    = 4;
  localparam int FLAG_CMD  = 0;
  localparam int FLAG_PHYS = 1;
  localparam int FLAG_STR  = 2;
  localparam int FLAG_ABT  = 3;
  localparam int SIZE_W    = 4;

endpackage

// File: rtl/txcmd_dpath.sv
module txcmd_dpath
  import txcmd_pkg::*;
#(
  parameter int UID_W   = 16,
  parameter int CAUSE_W = 4,
  parameter int ADDR_W  = 48,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strobe,
  input  logic [1:0]         cmdKind,
  input  logic [UID_W-1:0]   cmdUid,
  input  logic               cmdNested,
  input  logic [CAUSE_W-1:0] abortCause,
  input  logic [UID_W-1:0]   rspUid,
  input  logic [DATA_W-1:0]  rspData,
  output logic               acceptLocal,
  output logic               acceptAbort,
  output logic               curIsAbort,
  output logic               uidMatch,
  output logic [UID_W-1:0]   curUid,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [SIZE_W-1:0]  reqSize,
  output logic [1:0]         reqKind,
  output logic [FLAG_W-1:0]  reqFlags,
  output logic [CAUSE_W-1:0] reqCause,
  output logic [DATA_W-1:0]  bufData
);

  localparam int BYTES = DATA_W / 8;

  logic [1:0]         curKind;
  logic [CAUSE_W-1:0] curCause;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curUid   <= '0;
      curKind  <= TX_BEGIN;
      curCause <= '0;
    end else if (strobe.capture) begin
      curUid   <= cmdUid;
      curKind  <= cmdKind;
      curCause <= cmdKind[1] ? abortCause : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bufData <= '0;
    else if (strobe.zeroBuf)   bufData <= '0;
    else if (strobe.presetBuf) bufData <= DATA_W'(1);
    else if (strobe.loadRsp)   bufData <= rspData;
  end

  assign acceptAbort = cmdKind[1];
  assign acceptLocal = cmdNested && !cmdKind[1];
  assign curIsAbort  = curKind[1];
  assign uidMatch    = (rspUid == curUid);

  always_comb begin
    reqFlags            = '0;
    reqFlags[FLAG_PHYS] = 1'b1;
    reqFlags[FLAG_CMD]  = !curIsAbort;
    reqFlags[FLAG_STR]  = curIsAbort;
    reqFlags[FLAG_ABT]  = curIsAbort;
  end

  assign reqAddr  = '0;
  assign reqSize  = SIZE_W'(BYTES);
  assign reqKind  = curIsAbort ? TX_ABORT : curKind;
  assign reqCause = curCause;

endmodule

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
  import txcmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      acceptLocal,
  input  logic      acceptAbort,
  input  logic      curIsAbort,
  input  logic      reqReady,
  input  logic      rspValid,
  input  logic      uidMatch,
  output txStrobe_t strobe,
  output logic      cmdReady,
  output logic      reqValid,
  output logic      cplValid,
  output logic      holdLoads,
  output logic      holdStores,
  output logic      clrDispatchCnt,
  output logic      clrCommitCnt,
  output logic      errRefused,
  output logic      errUidMismatch
);

  txState_e state, stateNext;
  logic     setRefused, setMismatch;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    setRefused  = 1'b0;
    setMismatch = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        strobe.capture = 1'b1;
        if (acceptLocal) begin
          strobe.zeroBuf = 1'b1;
          stateNext      = ST_LOCAL;
        end else begin
          strobe.presetBuf = 1'b1;
          stateNext        = acceptAbort ? ST_CLEAR : ST_SEND;
        end
      end
      ST_LOCAL: stateNext = ST_IDLE;
      ST_CLEAR: stateNext = ST_SEND;
      ST_SEND: begin
        if (reqReady) begin
          stateNext = ST_WAIT;
        end else if (curIsAbort) begin
          setRefused = 1'b1;
          stateNext  = ST_DONE;
        end
      end
      ST_WAIT: if (rspValid) begin
        if (uidMatch) begin
          strobe.loadRsp = 1'b1;
          stateNext      = ST_DONE;
        end else begin
          setMismatch = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      errRefused     <= 1'b0;
      errUidMismatch <= 1'b0;
    end else begin
      state <= stateNext;
      if (setRefused)  errRefused     <= 1'b1;
      if (setMismatch) errUidMismatch <= 1'b1;
    end
  end

  assign cmdReady       = (state == ST_IDLE);
  assign reqValid       = (state == ST_SEND);
  assign cplValid       = (state == ST_LOCAL) || (state == ST_DONE);
  assign holdLoads      = (state != ST_IDLE);
  assign holdStores     = (state != ST_IDLE);
  assign clrDispatchCnt = (state == ST_CLEAR);
  assign clrCommitCnt   = (state == ST_CLEAR);

endmodule

// File: rtl/txcmd_issue.sv
module txcmd_issue
  import txcmd_pkg::*;
#(
  parameter int UID_W   = 16,
  parameter int CAUSE_W = 4,
  parameter int ADDR_W  = 48,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdKind,
  input  logic [UID_W-1:0]   cmdUid,
  input  logic               cmdNested,
  input  logic [CAUSE_W-1:0] abortCause,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [3:0]         reqSize,
  output logic [1:0]         reqKind,
  output logic [3:0]         reqFlags,
  output logic [UID_W-1:0]   reqUid,
  output logic [CAUSE_W-1:0] reqCause,
  input  logic               rspValid,
  input  logic [UID_W-1:0]   rspUid,
  input  logic [DATA_W-1:0]  rspData,
  output logic               cplValid,
  output logic [UID_W-1:0]   cplUid,
  output logic [DATA_W-1:0]  cplData,
  output logic               holdLoads,
  output logic               holdStores,
  output logic               clrDispatchCnt,
  output logic               clrCommitCnt,
  output logic               errRefused,
  output logic               errUidMismatch
);

  txStrobe_t        strobe;
  logic             acceptLocal, acceptAbort, curIsAbort, uidMatch;
  logic [UID_W-1:0] curUid;

  txcmd_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cmdValid      (cmdValid),
    .acceptLocal   (acceptLocal),
    .acceptAbort   (acceptAbort),
    .curIsAbort    (curIsAbort),
    .reqReady      (reqReady),
    .rspValid      (rspValid),
    .uidMatch      (uidMatch),
    .strobe        (strobe),
    .cmdReady      (cmdReady),
    .reqValid      (reqValid),
    .cplValid      (cplValid),
    .holdLoads     (holdLoads),
    .holdStores    (holdStores),
    .clrDispatchCnt(clrDispatchCnt),
    .clrCommitCnt  (clrCommitCnt),
    .errRefused    (errRefused),
    .errUidMismatch(errUidMismatch)
  );

  txcmd_dpath #(
    .UID_W  (UID_W),
    .CAUSE_W(CAUSE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdKind    (cmdKind),
    .cmdUid     (cmdUid),
    .cmdNested  (cmdNested),
    .abortCause (abortCause),
    .rspUid     (rspUid),
    .rspData    (rspData),
    .acceptLocal(acceptLocal),
    .acceptAbort(acceptAbort),
    .curIsAbort (curIsAbort),
    .uidMatch   (uidMatch),
    .curUid     (curUid),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqKind    (reqKind),
    .reqFlags   (reqFlags),
    .reqCause   (reqCause),
    .bufData    (cplData)
  );

  assign reqUid = curUid;
  assign cplUid = curUid;

endmodule

// File: rtl/txcmd_checker.sv
module txcmd_checker #(
  parameter int UID_W  = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdKind,
  input logic              cmdNested,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqKind,
  input logic [3:0]        reqFlags,
  input logic [UID_W-1:0]  reqUid,
  input logic              rspValid,
  input logic [UID_W-1:0]  rspUid,
  input logic [UID_W-1:0]  curUid,
  input logic              cplValid,
  input logic [DATA_W-1:0] cplData,
  input logic              holdLoads,
  input logic              holdStores,
  input logic              clrDispatchCnt,
  input logic              clrCommitCnt,
  input logic              errRefused,
  input logic              errUidMismatch
);

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !cmdReady);

  assert_barrier_raise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (holdLoads && holdStores));

  assert_barrier_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |=> (!holdLoads && !holdStores));

  assert_local_reply_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdNested && !cmdKind[1])
      |=> (cplValid && cplData == '0 && !reqValid));

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !reqFlags[3])
      |=> (reqValid && $stable(reqUid) && $stable(reqKind)));

  assert_clear_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFlags[3] && !$past(reqValid))
      |-> $past(clrDispatchCnt && clrCommitCnt));

  assert_refused_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errRefused) |-> $past(reqValid && !reqReady && reqFlags[3]));

  assert_mismatch_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errUidMismatch) |-> $past(rspValid && rspUid != curUid));

endmodule

bind txcmd_issue txcmd_checker #(.UID_W(UID_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cmdValid      (cmdValid),
  .cmdReady      (cmdReady),
  .cmdKind       (cmdKind),
  .cmdNested     (cmdNested),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqKind       (reqKind),
  .reqFlags      (reqFlags),
  .reqUid        (reqUid),
  .rspValid      (rspValid),
  .rspUid        (rspUid),
  .curUid        (curUid),
  .cplValid      (cplValid),
  .cplData       (cplData),
  .holdLoads     (holdLoads),
  .holdStores    (holdStores),
  .clrDispatchCnt(clrDispatchCnt),
  .clrCommitCnt  (clrCommitCnt),
  .errRefused    (errRefused),
  .errUidMismatch(errUidMismatch)
);

// File: tb/tb_txcmd_issue.sv
`timescale 1ns/1ps
module tb_txcmd_issue;
  localparam int UID_W = 16, CAUSE_W = 4, ADDR_W = 48, DATA_W = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdNested = 1'b0, reqReady = 1'b0, rspValid = 1'b0;
  logic [1:0] cmdKind = '0;
  logic [UID_W-1:0] cmdUid = '0, rspUid = '0;
  logic [CAUSE_W-1:0] abortCause = '0;
  logic [DATA_W-1:0] rspData = '0;
  logic cmdReady, reqValid, cplValid, holdLoads, holdStores;
  logic clrDispatchCnt, clrCommitCnt, errRefused, errUidMismatch;
  logic [ADDR_W-1:0] reqAddr;
  logic [3:0] reqSize, reqFlags;
  logic [1:0] reqKind;
  logic [UID_W-1:0] reqUid, cplUid;
  logic [CAUSE_W-1:0] reqCause;
  logic [DATA_W-1:0] cplData;

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txcmd_issue #(.UID_W(UID_W), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic offer(input logic [1:0] kind, input logic nested,
                       input logic [UID_W-1:0] uid, input logic [CAUSE_W-1:0] cause);
    cmdValid = 1'b1; cmdKind = kind; cmdNested = nested; cmdUid = uid; abortCause = cause;
    chkEq("R5 idle ready", cmdReady, 1);
    step();
    cmdValid = 1'b0;
  endtask

  task automatic runLocal(input logic [1:0] kind, input logic [UID_W-1:0] uid);
    offer(kind, 1'b1, uid, 4'h5);
    chkEq("R2 local cpl", cplValid, 1);
    chkEq("R2 local data", cplData, 0);
    chkEq("R2 local uid", cplUid, uid);
    chkEq("R2 no request", reqValid, 0);
    chkEq("R4 holds during", {holdLoads, holdStores}, 2'b11);
    step();
    chkEq("R4 holds released", {holdLoads, holdStores}, 2'b00);
    chkEq("R5 ready again", cmdReady, 1);
  endtask

  task automatic runCache(input logic [1:0] kind, input logic [UID_W-1:0] uid,
                          input int readyDly, input int rspDly,
                          input logic [DATA_W-1:0] data, input bit mismatch);
    offer(kind, 1'b0, uid, 4'h9);
    chkEq("R1 req valid", reqValid, 1);
    chkEq("R1 addr", reqAddr, 0);
    chkEq("R1 size", reqSize, 8);
    chkEq("R1 flags", reqFlags, 4'b0011);
    chkEq("R1 kind", reqKind, kind);
    chkEq("R1 uid", reqUid, uid);
    chkEq("R1 cause", reqCause, 0);
    chkEq("R4 holds", {holdLoads, holdStores}, 2'b11);
    cmdValid = 1'b1; cmdKind = 2'd0; cmdNested = 1'b1; cmdUid = uid + 1'b1;
    chkEq("R5 stalled", cmdReady, 0);
    cmdValid = 1'b0;
    for (int i = 0; i < readyDly; i++) begin
      step();
      chkEq("R10 held valid", reqValid, 1);
      chkEq("R10 held uid", reqUid, uid);
      chkEq("R10 held kind", reqKind, kind);
    end
    reqReady = 1'b1;
    step();
    reqReady = 1'b0;
    chkEq("R1 req dropped", reqValid, 0);
    for (int i = 0; i < rspDly; i++) begin
      step();
      chkEq("R3 no early cpl", cplValid, 0);
      chkEq("R4 holds waiting", {holdLoads, holdStores}, 2'b11);
    end
    if (mismatch) begin
      rspValid = 1'b1; rspUid = uid ^ 16'h0001; rspData = 64'hdead;
      step();
      rspValid = 1'b0;
      step();
      chkEq("R9 mismatch flag", errUidMismatch, 1);
      chkEq("R9 no cpl", cplValid, 0);
      chkEq("R9 still held", holdLoads, 1);
    end
    rspValid = 1'b1; rspUid = uid; rspData = data;
    step();
    rspValid = 1'b0;
    chkEq("R3 cpl", cplValid, 1);
    chkEq("R3 cpl data", cplData, data);
    chkEq("R3 cpl uid", cplUid, uid);
    chkEq("R4 holds at cpl", {holdLoads, holdStores}, 2'b11);
    step();
    chkEq("R4 released", {holdLoads, holdStores}, 2'b00);
    chkEq("R3 cpl single", cplValid, 0);
  endtask

  task automatic runAbort(input logic [UID_W-1:0] uid, input logic [CAUSE_W-1:0] cause,
                          input bit refuse);
    offer(2'd2, cause[0], uid, cause);
    chkEq("R7 clears", {clrDispatchCnt, clrCommitCnt}, 2'b11);
    chkEq("R7 no req yet", reqValid, 0);
    step();
    chkEq("R7 clear one cycle", {clrDispatchCnt, clrCommitCnt}, 2'b00);
    chkEq("R6 req valid", reqValid, 1);
    chkEq("R6 addr", reqAddr, 0);
    chkEq("R6 size", reqSize, 8);
    chkEq("R6 flags", reqFlags, 4'b1110);
    chkEq("R6 kind", reqKind, 2);
    chkEq("R6 cause", reqCause, cause);
    chkEq("R6 uid", reqUid, uid);
    if (refuse) begin
      step();
      chkEq("R8 refused flag", errRefused, 1);
      chkEq("R8 cpl", cplValid, 1);
      chkEq("R3 preset data", cplData, 1);
      step();
      chkEq("R8 sticky", errRefused, 1);
    end else begin
      reqReady = 1'b1;
      step();
      reqReady = 1'b0;
      rspValid = 1'b1; rspUid = uid; rspData = '0;
      step();
      rspValid = 1'b0;
      chkEq("R3 abort cpl", cplValid, 1);
      chkEq("R3 abort data", cplData, 0);
      step();
      chkEq("R4 abort released", holdStores, 0);
    end
  endtask

  task automatic checkReset();
    chkEq("R11 ready", cmdReady, 1);
    chkEq("R11 req", reqValid, 0);
    chkEq("R11 cpl", cplValid, 0);
    chkEq("R11 holds", {holdLoads, holdStores}, 2'b00);
    chkEq("R11 clears", {clrDispatchCnt, clrCommitCnt}, 2'b00);
    chkEq("R11 errors", {errRefused, errUidMismatch}, 2'b00);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    checkReset();
    for (int k = 0; k < 2; k++) begin
      for (int u = 0; u < 4; u++) runLocal(2'(k), 16'(u * 16'h1111 + k));
      for (int rd = 0; rd < 3; rd++)
        for (int sd = 0; sd < 3; sd++)
          runCache(2'(k), 16'(16'h0100 * rd + 16'h0010 * sd + k), rd, sd,
                   ((rd + sd) % 2 == 1) ? 64'd1 : 64'd0, 1'b0);
    end
    for (int c = 0; c < 16; c++) runAbort(16'(16'h0a00 + c), 4'(c), 1'b0);
    chkEq("R8 never refused", errRefused, 0);
    chkEq("R9 never mismatched", errUidMismatch, 0);
    runCache(2'd1, 16'h7777, 1, 1, 64'h0, 1'b1);
    chkEq("R9 sticky", errUidMismatch, 1);
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    step();
    checkReset();
    runAbort(16'h0bcd, 4'h3, 1'b1);
    runLocal(2'd0, 16'h0042);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule